// File: doc/BRIEF.md
# MSI-X Vector Table Register File

This block holds the interrupt vector table of a PCIe endpoint that signals with MSI-X, and stores it in the endpoint's own register space behind a 1 MiB memory BAR. Host software programs each vector with a 64-bit message address, a 32-bit message data word and a control word whose low bit masks the vector. A separate read-only pending array holds one bit per vector. The interrupt message generator sets and clears those bits.

Register traffic arrives already decoded from the link as single requests with a byte address inside the BAR, eight byte enables and 64-bit write data. One request may update two adjacent dwords of one entry. Reads answer one cycle later. A second, combinational lookup port lets the message generator fetch any entry's address, data and mask without using the register interface. The message generator needs the full address stored as {upper, lower}. Bits [1:0] of that address are always zero, which keeps the address dword aligned.

Top module: `msix_table_regs`

## Requirements
- R1: After reset every vector is masked (mask bit 1), its message address and data are zero, every pending bit is zero and rsp_valid_o is low.
- R2: Entry n starts at byte TABLE_BASE + 16*n, with TABLE_BASE = 0x80000. Within the entry, offset +0x0 holds the lower address, +0x4 the upper address, +0x8 the message data and +0xC the vector control word. A request addresses one 64-bit qword: address bits [2:0] are ignored, the dword at the lower offset sits in lanes [31:0] and the other in lanes [63:32]. lkp_addr_o presents {upper, lower} for the vector selected by lkp_idx_i.
- R3: Bits [1:0] of the lower message address read back as zero and appear as zero on lkp_addr_o, whatever is written.
- R4: Bit 0 of the vector control word is the mask, is writable and drives lkp_masked_o. All other control bits read as zero.
- R5: Each of the eight byte enables gates its own byte lane, so one request can write both dwords of a qword or any subset of its bytes.
- R6: A read request gives rsp_valid_o high with rsp_rdata_o in the cycle after the request is accepted. In every other cycle rsp_valid_o is low.
- R7: Reads of addresses outside the implemented table entries and pending words return zero, and writes to them change nothing.
- R8: The pending array is at PBA_BASE = 0x90000, with bit i of qword 0 for vector i. It is read-only: register writes to it have no effect.
- R9: pend_set_i[i] sets pending bit i and pend_clr_i[i] clears it at the next clock edge. When both are asserted in the same cycle, the set wins.
- R10: A table write shows on the lookup outputs right after the clock edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Byte address inside the BAR |
| req_be_i | input | 8 | Byte enables of the 64-bit lanes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| lkp_idx_i | input | 3 | Vector selected for lookup |
| lkp_addr_o | output | 64 | Message address of selected vector |
| lkp_data_o | output | 32 | Message data of selected vector |
| lkp_masked_o | output | 1 | Mask bit of selected vector |
| pend_set_i | input | 8 | Per-vector pending set pulses |
| pend_clr_i | input | 8 | Per-vector pending clear pulses |
| pend_o | output | 8 | Pending bits |

## Verification
Writes land at the clock edge that accepts them. The lookup outputs follow with no further register, so the bench drives each request on a falling edge and reads the lookup port on the next falling edge. It also samples the lookup once just before the accepting edge to confirm the old value still shows. Read data is registered once, so the bench holds a read for one cycle and samples rsp_valid_o and rsp_rdata_o on the following falling edge. It checks that rsp_valid_o falls again one cycle later. Pending set and clear pulses take effect at the next edge and are checked through a register read issued after the pulse.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef struct packed {
    logic [31:0] addr_hi;
    logic [31:0] addr_lo;
    logic [31:0] msg;
    logic        masked;
  } msix_entry_t;
endpackage

// File: rtl/msix_addr_dec.sv
module msix_addr_dec #(
  parameter int ADDR_W = 20,
  parameter int NUM_VEC = 8,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 20'h80000,
  parameter logic [ADDR_W-1:0] PBA_BASE = 20'h90000,
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int PBA_QW = (NUM_VEC + 63) / 64,
  localparam int PQ_W = (PBA_QW > 1) ? $clog2(PBA_QW) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tbl_hit_o,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output logic              tbl_qsel_o,
  output logic              pba_hit_o,
  output logic [PQ_W-1:0]   pba_qw_o
);
  localparam int TBL_BYTES = NUM_VEC * 16;
  localparam int PBA_BYTES = PBA_QW * 8;

  logic [ADDR_W-1:0] toff, poff;

  assign toff = addr_i - TABLE_BASE;
  assign poff = addr_i - PBA_BASE;

  assign tbl_hit_o  = (addr_i >= TABLE_BASE) && (toff < ADDR_W'(TBL_BYTES));
  assign tbl_idx_o  = toff[IDX_W+3:4];
  assign tbl_qsel_o = toff[3];
  assign pba_hit_o  = (addr_i >= PBA_BASE) && (poff < ADDR_W'(PBA_BYTES));
  assign pba_qw_o   = poff[PQ_W+2:3];
endmodule

// File: rtl/msix_vec_entry.sv
module msix_vec_entry
  import msix_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        qsel_i,
  input  logic [7:0]  be_i,
  input  logic [63:0] wdata_i,
  output msix_entry_t entry_o
);
  msix_entry_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.addr_hi <= '0;
      q.addr_lo <= '0;
      q.msg     <= '0;
      q.masked  <= 1'b1;
    end else if (wr_i) begin
      for (int b = 0; b < 4; b++) begin
        if (!qsel_i && be_i[b])   q.addr_lo[8*b +: 8] <= wdata_i[8*b +: 8];
        if (!qsel_i && be_i[b+4]) q.addr_hi[8*b +: 8] <= wdata_i[32+8*b +: 8];
        if (qsel_i && be_i[b])    q.msg[8*b +: 8]     <= wdata_i[8*b +: 8];
      end
      // dword alignment: low two address bits never stored
      if (!qsel_i && be_i[0]) q.addr_lo[1:0] <= 2'b00;
      if (qsel_i && be_i[4])  q.masked <= wdata_i[32];
    end
  end

  assign entry_o = q;

  p_lo_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o.addr_lo[1:0] == 2'b00);

  p_msg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && qsel_i && be_i[3:0] == 4'h0) |=> $stable(entry_o.msg));
endmodule

// File: rtl/msix_pba.sv
module msix_pba #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[g]) bit_q <= 1'b1;
      else if (clr_i[g]) bit_q <= 1'b0;
    end
    assign pend_o[g] = bit_q;

    p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]);
    p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[g] && !clr_i[g]) |=> $stable(pend_o[g]));
  end
endmodule

// File: rtl/msix_table_regs.sv
module msix_table_regs
  import msix_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NUM_VEC = 8,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 20'h80000,
  parameter logic [ADDR_W-1:0] PBA_BASE = 20'h90000,
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [7:0]         req_be_i,
  input  logic [63:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [63:0]        rsp_rdata_o,
  input  logic [IDX_W-1:0]   lkp_idx_i,
  output logic [63:0]        lkp_addr_o,
  output logic [31:0]        lkp_data_o,
  output logic               lkp_masked_o,
  input  logic [NUM_VEC-1:0] pend_set_i,
  input  logic [NUM_VEC-1:0] pend_clr_i,
  output logic [NUM_VEC-1:0] pend_o
);
  localparam int PBA_QW = (NUM_VEC + 63) / 64;
  localparam int PQ_W = (PBA_QW > 1) ? $clog2(PBA_QW) : 1;

  logic             tbl_hit, tbl_qsel, pba_hit;
  logic [IDX_W-1:0] tbl_idx;
  logic [PQ_W-1:0]  pba_qw;
  logic             rd_req, wr_req;
  logic [63:0]      rd_q;
  msix_entry_t      ent [NUM_VEC];
  msix_entry_t      lkp_ent;
  logic [PBA_QW*64-1:0] pend_pad;

  assign rd_req = req_valid_i && !req_write_i;
  assign wr_req = req_valid_i && req_write_i;

  msix_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC),
    .TABLE_BASE(TABLE_BASE), .PBA_BASE(PBA_BASE)
  ) u_dec (
    .addr_i    (req_addr_i),
    .tbl_hit_o (tbl_hit),
    .tbl_idx_o (tbl_idx),
    .tbl_qsel_o(tbl_qsel),
    .pba_hit_o (pba_hit),
    .pba_qw_o  (pba_qw)
  );

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic wr_sel;
    assign wr_sel = wr_req && tbl_hit && (tbl_idx == IDX_W'(g));
    msix_vec_entry u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_sel),
      .qsel_i (tbl_qsel),
      .be_i   (req_be_i),
      .wdata_i(req_wdata_i),
      .entry_o(ent[g])
    );
  end

  msix_pba #(.NUM_VEC(NUM_VEC)) u_pba (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (pend_set_i),
    .clr_i (pend_clr_i),
    .pend_o(pend_o)
  );

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend_o;
  end

  always_comb begin
    rd_q = '0;
    if (tbl_hit) begin
      if (tbl_qsel) rd_q = {31'b0, ent[tbl_idx].masked, ent[tbl_idx].msg};
      else          rd_q = {ent[tbl_idx].addr_hi, ent[tbl_idx].addr_lo};
    end else if (pba_hit) begin
      for (int q = 0; q < PBA_QW; q++)
        if (pba_qw == PQ_W'(q)) rd_q = pend_pad[64*q +: 64];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_req;
      rsp_rdata_o <= rd_req ? rd_q : '0;
    end
  end

  always_comb begin
    lkp_ent = '0;
    if ({1'b0, lkp_idx_i} < (IDX_W+1)'(NUM_VEC)) lkp_ent = ent[lkp_idx_i];
  end

  assign lkp_addr_o   = {lkp_ent.addr_hi, lkp_ent.addr_lo};
  assign lkp_data_o   = lkp_ent.msg;
  assign lkp_masked_o = lkp_ent.masked;

  p_rsp_due_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o);
  p_rsp_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rsp_valid_o);
  p_lkp_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_addr_o[1:0] == 2'b00);
  p_ctrl_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && tbl_hit && tbl_qsel) |=> (rsp_rdata_o[63:33] == '0));
  p_unmapped_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !tbl_hit && !pba_hit) |=> (rsp_rdata_o == '0));
endmodule

// File: tb/tb_msix_table_regs.sv
module tb_msix_table_regs;
  localparam logic [19:0] TB = 20'h80000;
  localparam logic [19:0] PB = 20'h90000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [2:0]  lkp_idx = '0;
  logic [63:0] lkp_addr;
  logic [31:0] lkp_data;
  logic        lkp_masked;
  logic [7:0]  pend_set = '0, pend_clr = '0;
  logic [7:0]  pend;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msix_table_regs dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .lkp_idx_i(lkp_idx), .lkp_addr_o(lkp_addr), .lkp_data_o(lkp_data),
    .lkp_masked_o(lkp_masked),
    .pend_set_i(pend_set), .pend_clr_i(pend_clr), .pend_o(pend)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [19:0] a, input logic [63:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " R6 valid"}, {63'b0, rsp_valid}, 64'd1);
    chk(req, rsp_rdata, exp);
    @(negedge clk);
    chk("R6 valid drops", {63'b0, rsp_valid}, 64'd0);
  endtask

  task automatic lkp_chk(input string req, input int v, input logic [63:0] a,
                         input logic [31:0] d, input logic m);
    lkp_idx = 3'(v);
    #1;
    chk({req, " addr"}, lkp_addr, a);
    chk({req, " data"}, {32'b0, lkp_data}, {32'b0, d});
    chk({req, " mask"}, {63'b0, lkp_masked}, {63'b0, m});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    chk("R1 pend", {56'b0, pend}, 64'd0);
    for (int v = 0; v < 8; v++) lkp_chk("R1 reset", v, 64'd0, 32'd0, 1'b1);
    rd_chk("R1 pba read", PB, 64'd0);
  endtask

  task automatic t_full_qword;
    wr(TB + 20'h20, 8'hFF, 64'h1234_5678_9ABC_DEF3);
    lkp_chk("R2 R3 R5 entry2 addr", 2, 64'h1234_5678_9ABC_DEF0, 32'd0, 1'b1);
    rd_chk("R2 R3 readback", TB + 20'h20, 64'h1234_5678_9ABC_DEF0);
    rd_chk("R2 addr[2:0] ignored", TB + 20'h24, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_ctrl;
    wr(TB + 20'h28, 8'hFF, 64'hFFFF_FFFE_CAFE_0001);
    lkp_chk("R4 unmask", 2, 64'h1234_5678_9ABC_DEF0, 32'hCAFE_0001, 1'b0);
    rd_chk("R4 ctrl zero bits", TB + 20'h28, 64'h0000_0000_CAFE_0001);
    wr(TB + 20'h28, 8'hF0, 64'hFFFF_FFFF_0000_0000);
    rd_chk("R4 R5 remask data kept", TB + 20'h28, 64'h0000_0001_CAFE_0001);
    lkp_chk("R4 mask out", 2, 64'h1234_5678_9ABC_DEF0, 32'hCAFE_0001, 1'b1);
  endtask

  task automatic t_byte_en;
    wr(TB + 20'h50, 8'b0100_0010, 64'hAAAA_BBBB_CCCC_DDDD);
    rd_chk("R5 sparse bytes", TB + 20'h50, 64'h00AA_0000_0000_DD00);
    wr(TB + 20'h50, 8'h01, 64'h0000_0000_0000_00FF);
    rd_chk("R3 R5 low byte", TB + 20'h50, 64'h00AA_0000_0000_DDFC);
  endtask

  task automatic t_unmapped;
    wr(TB + 20'h80, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(TB - 20'h8, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(PB + 20'h8, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R7 past table", TB + 20'h80, 64'd0);
    rd_chk("R7 below table", TB - 20'h8, 64'd0);
    rd_chk("R7 past pba", PB + 20'h8, 64'd0);
    lkp_chk("R7 entry0 intact", 0, 64'd0, 32'd0, 1'b1);
    lkp_chk("R7 entry7 intact", 7, 64'd0, 32'd0, 1'b1);
    rd_chk("R7 pba intact", PB, 64'd0);
  endtask

  task automatic t_pba;
    @(negedge clk); pend_set = 8'h85;
    @(negedge clk); pend_set = 8'h00;
    rd_chk("R9 set", PB, 64'h85);
    wr(PB, 8'hFF, 64'h0);
    rd_chk("R8 write ignored", PB, 64'h85);
    @(negedge clk); pend_set = 8'h01; pend_clr = 8'h05;
    @(negedge clk); pend_set = 8'h00; pend_clr = 8'h00;
    chk("R9 set wins clr", {56'b0, pend}, 64'h81);
    rd_chk("R9 pba read", PB, 64'h81);
  endtask

  task automatic t_lkp_timing;
    lkp_idx = 3'd7;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = TB + 20'h78;
    req_be = 8'h0F; req_wdata = 64'h0000_0000_5A5A_1234;
    #1;
    chk("R10 before edge", {32'b0, lkp_data}, 64'd0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R10 after edge", {32'b0, lkp_data}, 64'h5A5A_1234);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_qword();
    t_ctrl();
    t_byte_en();
    t_unmapped();
    t_pba();
    t_lkp_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule